// File: doc/BRIEF.md
# ADC Sample-Clock and Configuration Controller

This block sits between an on-chip register bus and a 10-bit parallel ADC. It keeps one control word, which sets the ADC clock rate, the sleep pin and the chip-select pin. A second register drives the channel-select pin. The block also keeps the newest conversion result so that software can read it back.

The ADC clock comes from the bus clock in one of two ways. In divide mode, a reloading counter toggles a phase flop, so the ADC clock runs at the bus rate divided by twice the prescaler value plus two. In bypass mode, the bus clock goes straight out to the ADC.

On each rising edge of the generated clock, the ADC data is latched and `smp_vld_o` is raised for one bus cycle. The sample path has no back-pressure:
- No ready signal exists.
- The stored sample is overwritten at the next rising edge whether or not anyone has read it.
- In bypass mode the strobe stays high on every cycle.

Top module: `adc_pace_ctrl`

## Requirements
- R1: While reset is held, the ADC clock and the sample strobe are low, sleep is 0, chip select is 1 and channel select is 0. The control word at address 0 then reads 0x0A00.
- R2: A request (cyc and stb high) is acknowledged by `ack_o` at the first clock edge, for exactly one cycle. The read data is valid in that same cycle. With stb low, no ack appears.
- R3: Address 0 holds the control word. Bits 11:0 are writable and bits 15:12 read as zero: writing 0xF5A7 reads back 0x05A7.
- R4: Control bit 10 drives `adc_sleep_o` and control bit 11 drives `adc_cs_o`.
- R5: When control bit 9 is 1, the ADC clock is high for N+1 bus cycles and then low for N+1 cycles, where N is control bits 8:0.
- R6: When control bit 9 is 0, `adc_clk_o` follows the bus clock, and a sample is taken with the strobe high on every cycle.
- R7: A write to address 0 restarts the divider with the clock low. In divide mode the first rising edge comes N+1 bus edges after the write edge.
- R8: The ADC data is latched on each rising edge of the generated clock, with `smp_vld_o` high for that one cycle. Address 1 reads the latched sample in bits 9:0, with zeros above.
- R9: Writing address 2 sets `adc_chan_o` from data bit 0, and address 2 reads it back in bit 0. Address 3 reads zero, and writes to it change no register.
- R10: A synchronous reset in the middle of operation restores the defaults. After release, the first rising ADC clock edge comes at the first bus edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle active |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | 2 | Register address |
| dat_i | input | 16 | Write data |
| dat_o | output | 16 | Read data |
| ack_o | output | 1 | Access acknowledge |
| adc_data_i | input | 10 | ADC conversion result |
| adc_clk_o | output | 1 | Generated ADC clock |
| adc_sleep_o | output | 1 | ADC sleep control |
| adc_cs_o | output | 1 | ADC chip select |
| adc_chan_o | output | 1 | ADC channel select |
| smp_vld_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The divider is run at N=0, N=3 and N=5, each started by a fresh control write while the previous setting is still running. These runs separate off-by-one errors in the reload compare from errors in the restart phase. A ramp on the ADC data, changing every cycle, shows which edge the sample register latched. Any skew between the strobe and the clock edge then appears as a wrong read-back value. A bypass run, with the clock and strobe sampled in both half-periods, separates the clock multiplexer from the divider. Writes with all-ones upper bits, and writes to the unused address, show that no stray bit is stored.

// File: rtl/adc_pace_pkg.sv
package adc_pace_pkg;
  typedef enum logic [1:0] {
    RA_CFG  = 2'd0,
    RA_SMP  = 2'd1,
    RA_CHAN = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/adc_pace_regs.sv
module adc_pace_regs
  import adc_pace_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int DATA_W = 10,
  parameter int PRE_W = 9,
  parameter logic [15:0] CFG_RST = 16'h0A00
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [1:0]        adr_i,
  input  logic [BUS_W-1:0]  dat_i,
  output logic [BUS_W-1:0]  dat_o,
  output logic              ack_o,
  input  logic [DATA_W-1:0] smp_i,
  output logic              cfg_wr_o,
  output logic [PRE_W-1:0]  pre_n_o,
  output logic              pre_en_o,
  output logic              sleep_o,
  output logic              cs_o,
  output logic              chan_o
);
  localparam int EN_BIT  = PRE_W;
  localparam int SLP_BIT = PRE_W + 1;
  localparam int CS_BIT  = PRE_W + 2;
  localparam int CFG_W   = PRE_W + 3;

  logic [CFG_W-1:0] cfg_q;
  logic             chan_q;
  logic             ack_q;
  logic [BUS_W-1:0] dat_q;
  logic [BUS_W-1:0] rd_mux;
  logic             req;
  logic             wr;
  reg_addr_e        sel;

  assign sel = reg_addr_e'(adr_i);
  assign req = cyc_i && stb_i && !ack_q;
  assign wr  = req && we_i;

  always_comb begin
    rd_mux = '0;
    case (sel)
      RA_CFG:  rd_mux[CFG_W-1:0] = cfg_q;
      RA_SMP:  rd_mux[DATA_W-1:0] = smp_i;
      RA_CHAN: rd_mux[0] = chan_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q  <= CFG_RST[CFG_W-1:0];
      chan_q <= 1'b0;
      ack_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      ack_q <= req;
      if (req) dat_q <= rd_mux;
      if (wr && sel == RA_CFG) cfg_q <= dat_i[CFG_W-1:0];
      if (wr && sel == RA_CHAN) chan_q <= dat_i[0];
    end
  end

  assign dat_o    = dat_q;
  assign ack_o    = ack_q;
  assign cfg_wr_o = wr && sel == RA_CFG;
  assign pre_n_o  = cfg_q[PRE_W-1:0];
  assign pre_en_o = cfg_q[EN_BIT];
  assign sleep_o  = cfg_q[SLP_BIT];
  assign cs_o     = cfg_q[CS_BIT];
  assign chan_o   = chan_q;

  // R2
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |=> !ack_o);
  // R2
  ack_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |-> $past(cyc_i && stb_i));
  // R4
  pin_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(cfg_wr_o) |-> (sleep_o == $past(dat_i[SLP_BIT]) && cs_o == $past(dat_i[CS_BIT])));
  // R9
  chan_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(wr && adr_i == 2'd2) |-> (chan_o == $past(dat_i[0])));
endmodule

// File: rtl/adc_pace_div.sv
module adc_pace_div #(
  parameter int PRE_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cfg_wr_i,
  input  logic             pre_en_i,
  input  logic [PRE_W-1:0] pre_n_i,
  output logic             div_clk_o,
  output logic             rise_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             div_q;
  logic             at_top;

  assign at_top = (cnt_q == pre_n_i);
  assign rise_o = !cfg_wr_i && (!pre_en_i || (at_top && !div_q));
  assign div_clk_o = div_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || cfg_wr_i || !pre_en_i) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (at_top) begin
      cnt_q <= '0;
      div_q <= !div_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pre_en_i |-> cnt_q <= pre_n_i);
  // R5
  toggle_at_top_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (pre_en_i && $past(pre_en_i) && !$past(cfg_wr_i) && div_q != $past(div_q))
      |-> $past(cnt_q) == $past(pre_n_i));
  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(cfg_wr_i) |-> (cnt_q == '0 && !div_q));
endmodule

// File: rtl/adc_pace_cap.sv
module adc_pace_cap #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] smp_o,
  output logic              vld_o
);
  logic [DATA_W-1:0] smp_q;
  logic              vld_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= take_i;
      if (take_i) smp_q <= data_i;
    end
  end

  assign smp_o = smp_q;
  assign vld_o = vld_q;

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !vld_q |-> $stable(smp_q));
  // R8
  latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_q |-> smp_q == $past(data_i));
endmodule

// File: rtl/adc_pace_ctrl.sv
module adc_pace_ctrl #(
  parameter int BUS_W = 16,
  parameter int DATA_W = 10,
  parameter int PRE_W = 9,
  parameter logic [15:0] CFG_RST = 16'h0A00
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [1:0]        adr_i,
  input  logic [BUS_W-1:0]  dat_i,
  output logic [BUS_W-1:0]  dat_o,
  output logic              ack_o,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_clk_o,
  output logic              adc_sleep_o,
  output logic              adc_cs_o,
  output logic              adc_chan_o,
  output logic              smp_vld_o
);
  logic              cfg_wr;
  logic [PRE_W-1:0]  pre_n;
  logic              pre_en;
  logic              div_clk;
  logic              rise;
  logic [DATA_W-1:0] smp;

  adc_pace_regs #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .PRE_W(PRE_W), .CFG_RST(CFG_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o), .smp_i(smp),
    .cfg_wr_o(cfg_wr), .pre_n_o(pre_n), .pre_en_o(pre_en),
    .sleep_o(adc_sleep_o), .cs_o(adc_cs_o), .chan_o(adc_chan_o)
  );

  adc_pace_div #(.PRE_W(PRE_W)) u_div (
    .clk_i(clk_i), .rst_i(rst_i), .cfg_wr_i(cfg_wr), .pre_en_i(pre_en),
    .pre_n_i(pre_n), .div_clk_o(div_clk), .rise_o(rise)
  );

  adc_pace_cap #(.DATA_W(DATA_W)) u_cap (
    .clk_i(clk_i), .rst_i(rst_i), .take_i(rise), .data_i(adc_data_i),
    .smp_o(smp), .vld_o(smp_vld_o)
  );

  assign adc_clk_o = pre_en ? div_clk : clk_i;

  // R8
  vld_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (smp_vld_o && pre_en) |-> div_clk);
  // R6
  bypass_vld_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pre_en && !$past(cfg_wr)) |-> smp_vld_o);
endmodule

// File: tb/sim_adc_pace_ctrl.sv
module sim_adc_pace_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [1:0]  adr = 2'd0;
  logic [15:0] dat_i = 16'h0;
  logic [15:0] dat_o;
  logic        ack;
  logic [9:0]  adc_data = 10'h0;
  logic        adc_clk, adc_sleep, adc_cs, adc_chan, smp_vld;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  adc_pace_ctrl u0 (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack),
    .adc_data_i(adc_data), .adc_clk_o(adc_clk), .adc_sleep_o(adc_sleep),
    .adc_cs_o(adc_cs), .adc_chan_o(adc_chan), .smp_vld_o(smp_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic w, input logic [1:0] a, input logic [15:0] d,
                          output logic [15:0] q);
    int waited;
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat_i = d;
    @(posedge clk); #1;
    waited = 1;
    while (!ack && waited < 8) begin
      @(posedge clk); #1; waited++;
    end
    chk("R2 ack at first edge", 32'(waited), 32'd1);
    q = dat_o;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    logic [15:0] q;
    bus_xfer(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] q);
    bus_xfer(1'b0, a, 16'h0, q);
  endtask

  task automatic t_reset;
    logic [15:0] q;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 adc clock low in reset", 32'(adc_clk), 32'd0);
    chk("R1 strobe low in reset", 32'(smp_vld), 32'd0);
    chk("R1 sleep default", 32'(adc_sleep), 32'd0);
    chk("R1 cs default", 32'(adc_cs), 32'd1);
    chk("R1 chan default", 32'(adc_chan), 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R10 first rise at first edge after release", 32'(adc_clk), 32'd1);
    rd(2'd0, q);
    chk("R1 control word default", 32'(q), 32'h0A00);
  endtask

  task automatic t_ack;
    int hi = 0;
    @(negedge clk);
    cyc = 1'b1; stb = 1'b0;
    repeat (3) begin @(posedge clk); #1; if (ack) hi++; end
    chk("R2 no ack without stb", 32'(hi), 32'd0);
    @(negedge clk); stb = 1'b1; we = 1'b0; adr = 2'd0;
    @(posedge clk); #1; if (ack) hi++;
    @(negedge clk); stb = 1'b0; cyc = 1'b0;
    repeat (3) begin @(posedge clk); #1; if (ack) hi++; end
    chk("R2 one ack cycle per access", 32'(hi), 32'd1);
  endtask

  task automatic t_regs;
    logic [15:0] q;
    wr(2'd0, 16'hF5A7);
    rd(2'd0, q);
    chk("R3 upper bits read zero", 32'(q), 32'h05A7);
    chk("R4 sleep from bit 10", 32'(adc_sleep), 32'd1);
    chk("R4 cs from bit 11", 32'(adc_cs), 32'd0);
    wr(2'd0, 16'h0800);
    chk("R4 sleep cleared", 32'(adc_sleep), 32'd0);
    chk("R4 cs set", 32'(adc_cs), 32'd1);
    wr(2'd2, 16'hFFFF);
    chk("R9 chan set from bit 0", 32'(adc_chan), 32'd1);
    rd(2'd2, q);
    chk("R9 chan read back", 32'(q), 32'h0001);
    wr(2'd3, 16'h1234);
    rd(2'd3, q);
    chk("R9 address 3 reads zero", 32'(q), 32'h0000);
    rd(2'd0, q);
    chk("R9 address 3 write leaves control", 32'(q), 32'h0800);
    rd(2'd2, q);
    chk("R9 address 3 write leaves chan", 32'(q), 32'h0001);
    wr(2'd2, 16'hFFFE);
    chk("R9 chan cleared", 32'(adc_chan), 32'd0);
  endtask

  task automatic t_divide(input int n);
    logic [15:0] q;
    int per;
    per = 2 * (n + 1);
    wr(2'd0, 16'h0A00 | 16'(n));
    for (int k = 1; k <= 3 * (n + 1); k++) begin
      adc_data = 10'h200 | 10'(k);
      @(posedge clk); #1;
      if (k <= n + 1)
        chk($sformatf("R7 restart phase n=%0d k=%0d", n, k), 32'(adc_clk), 32'((k / (n + 1)) % 2));
      else
        chk($sformatf("R5 clock level n=%0d k=%0d", n, k), 32'(adc_clk), 32'((k / (n + 1)) % 2));
      chk($sformatf("R8 strobe n=%0d k=%0d", n, k), 32'(smp_vld), 32'((k % per) == n + 1));
      @(negedge clk);
    end
    rd(2'd1, q);
    chk($sformatf("R8 latched sample n=%0d", n), 32'(q), 32'(16'h0200 | 16'(3 * (n + 1))));
  endtask

  task automatic t_bypass;
    logic [15:0] q;
    wr(2'd0, 16'h0003);
    adc_data = 10'h2AA;
    @(posedge clk); #2;
    chk("R6 clock high with bus clock", 32'(adc_clk), 32'd1);
    chk("R6 strobe every cycle", 32'(smp_vld), 32'd1);
    @(negedge clk); #2;
    chk("R6 clock low with bus clock", 32'(adc_clk), 32'd0);
    @(posedge clk); #2;
    chk("R6 strobe stays high", 32'(smp_vld), 32'd1);
    rd(2'd1, q);
    chk("R6 sample each cycle", 32'(q), 32'h02AA);
  endtask

  task automatic t_midreset;
    logic [15:0] q;
    wr(2'd0, 16'h0505);
    wr(2'd2, 16'h0001);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R10 chan cleared", 32'(adc_chan), 32'd0);
    chk("R10 cs restored", 32'(adc_cs), 32'd1);
    chk("R10 sleep restored", 32'(adc_sleep), 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R10 divider cleared", 32'(adc_clk), 32'd1);
    rd(2'd0, q);
    chk("R10 control restored", 32'(q), 32'h0A00);
  endtask

  initial begin
    t_reset();
    t_ack();
    t_regs();
    t_divide(0);
    t_divide(3);
    t_divide(5);
    t_bypass();
    t_divide(2);
    t_midreset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule